// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This block turns an operand specifier into an operand value. A request carries a mode code, a 32-bit field, two register numbers, an operand size and the current program counter. Depending on the mode, the block returns the field itself or a register value, or it forms an effective address and fetches the operand from memory. The memory interface is a single read port with a valid/ready handshake.

A sequencer issues zero, one or two memory reads per request. The memory-indirect mode first reads a pointer and then reads the operand at that pointer. For the post-increment and pre-decrement modes, the updated pointer register is written back through a dedicated register-file write port. This write happens in the same cycle as the completion pulse.

The unit takes one request at a time. It raises `reqReady` only while it is waiting for work. When an operation finishes, it pulses `done` for one cycle and presents the operand and the effective address.

Top module: `operand_fetch`

## Requirements
- R1: Mode code 0 (immediate) returns `reqField` as the operand with `effAddr` 0. It makes no memory read and no writeback, and `done` is seen in the second cycle after the accepting edge.
- R2: Mode code 1 (register) returns the value of register `reqBaseReg` as the operand with `effAddr` 0, with no memory read and no writeback.
- R3: The single-read modes use these effective addresses: mode 2 (direct) uses the field; mode 3 (register indirect) uses the base register; mode 4 (base plus displacement) uses the base register plus the field taken as a signed displacement; mode 7 (PC-relative) uses `pc` plus the signed field. Each makes exactly one read at that address and returns the read data as the operand.
- R4: Mode 5 (indexed) reads once at base register + index register × step + field, where the step comes from R8.
- R5: Mode 6 (memory indirect) reads at the field address, then reads at the returned pointer. It returns the second read's data, and `effAddr` is the pointer.
- R6: Mode 8 (post-increment) reads at the base register value and writes back base + step to the base register.
- R7: Mode 9 (pre-decrement) reads at base − step, writes that value back to the base register, and reports it as `effAddr`.
- R8: `reqSize` picks the step in bytes: 0 gives 1, 1 gives 2, and 2 or 3 give 4.
- R9: `done` lasts exactly one cycle. `wbEn` is asserted only together with `done`, and only for modes 8 and 9.
- R10: A request is taken only while `reqReady` is high. `reqValid` raised during a busy operation is ignored and yields no extra completion.
- R11: Once `memValid` is raised, it stays high with `memAddr` unchanged until a cycle in which `memReady` is high.
- R12: Mode codes 10 to 15 behave as immediate.
- R13: After reset, `reqReady` is 1 and `memValid`, `done` and `wbEn` are 0.
- R14: Latency from the accepting edge to `done` is two cycles plus the number of cycles with `memValid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqReady | output | 1 | Unit idle, request is taken this cycle |
| reqMode | input | 4 | Addressing mode code |
| reqField | input | DATA_W | Immediate, address or signed displacement |
| reqBaseReg | input | REG_AW | Base/pointer register number |
| reqIndexReg | input | REG_AW | Index register number |
| reqSize | input | 2 | Operand size code (step selection) |
| pc | input | DATA_W | Current program counter |
| rfRdAddrA | output | REG_AW | Register read port A address (base) |
| rfRdDataA | input | DATA_W | Register read port A data |
| rfRdAddrB | output | REG_AW | Register read port B address (index) |
| rfRdDataB | input | DATA_W | Register read port B data |
| memValid | output | 1 | Memory read request |
| memAddr | output | DATA_W | Memory read address |
| memReady | input | 1 | Memory accepts and returns data this cycle |
| memRdata | input | DATA_W | Memory read data, valid with memReady |
| done | output | 1 | One-cycle completion pulse |
| operand | output | DATA_W | Resolved operand value |
| effAddr | output | DATA_W | Effective address of the operand |
| wbEn | output | 1 | Register writeback enable |
| wbReg | output | REG_AW | Register writeback number |
| wbData | output | DATA_W | Register writeback value |

## Verification
Every mode code is driven with register and field values chosen so that a wrong address formula gives a different read address. Negative displacements tell signed from unsigned adds, and each size code on the indexed and auto modes separates the three step widths. Memory stalls of zero to three cycles, including stalls on both reads of the indirect mode, test the address hold and the latency rule. Back-to-back auto-mode requests on one register confirm that the writeback lands before the next read. A request pulse during a busy operation confirms that only idle requests are taken.

// File: rtl/ofu_pkg.sv
package ofu_pkg;

  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_IMM      = 4'd0;
  localparam logic [MODE_W-1:0] MODE_REG      = 4'd1;
  localparam logic [MODE_W-1:0] MODE_DIRECT   = 4'd2;
  localparam logic [MODE_W-1:0] MODE_REGIND   = 4'd3;
  localparam logic [MODE_W-1:0] MODE_BASEDISP = 4'd4;
  localparam logic [MODE_W-1:0] MODE_INDEXED  = 4'd5;
  localparam logic [MODE_W-1:0] MODE_MEMIND   = 4'd6;
  localparam logic [MODE_W-1:0] MODE_PCREL    = 4'd7;
  localparam logic [MODE_W-1:0] MODE_POSTINC  = 4'd8;
  localparam logic [MODE_W-1:0] MODE_PREDEC   = 4'd9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_MEM1, ST_MEM2, ST_WB, ST_DONE
  } fsmState_e;

  typedef struct packed {
    logic capReq;    // latch request fields
    logic capAddr;   // latch effective address and non-memory operand
    logic capRead;   // latch read data as operand
    logic capPtr;    // latch read data as new address (indirect)
    logic memValid;
    logic done;
    logic wbEn;
  } ctrlStrobe_t;

  function automatic logic modeNeedsMem(input logic [MODE_W-1:0] m);
    return (m >= MODE_DIRECT) && (m <= MODE_PREDEC);
  endfunction

  function automatic logic modeIsAuto(input logic [MODE_W-1:0] m);
    return (m == MODE_POSTINC) || (m == MODE_PREDEC);
  endfunction

endpackage

// File: rtl/ofu_ctrl.sv
module ofu_ctrl
  import ofu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [MODE_W-1:0] curMode,
  input  logic              memReady,
  output logic              reqReady,
  output ctrlStrobe_t       stb
);

  fsmState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.capReq = 1'b1;
          nextState  = ST_ADDR;
        end
      end
      ST_ADDR: begin
        stb.capAddr = 1'b1;
        nextState   = modeNeedsMem(curMode) ? ST_MEM1 : ST_DONE;
      end
      ST_MEM1: begin
        stb.memValid = 1'b1;
        if (memReady) begin
          if (curMode == MODE_MEMIND) begin
            stb.capPtr = 1'b1;
            nextState  = ST_MEM2;
          end else begin
            stb.capRead = 1'b1;
            nextState   = modeIsAuto(curMode) ? ST_WB : ST_DONE;
          end
        end
      end
      ST_MEM2: begin
        stb.memValid = 1'b1;
        if (memReady) begin
          stb.capRead = 1'b1;
          nextState   = ST_DONE;
        end
      end
      ST_WB: begin
        stb.done  = 1'b1;
        stb.wbEn  = 1'b1;
        nextState = ST_IDLE;
      end
      ST_DONE: begin
        stb.done  = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/ofu_dpath.sv
module ofu_dpath
  import ofu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [MODE_W-1:0] reqMode,
  input  logic [DATA_W-1:0] reqField,
  input  logic [REG_AW-1:0] reqBaseReg,
  input  logic [REG_AW-1:0] reqIndexReg,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] pc,
  input  logic [DATA_W-1:0] rfRdDataA,
  input  logic [DATA_W-1:0] rfRdDataB,
  input  logic [DATA_W-1:0] memRdata,
  output logic [MODE_W-1:0] curMode,
  output logic [REG_AW-1:0] rfRdAddrA,
  output logic [REG_AW-1:0] rfRdAddrB,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] effAddr,
  output logic [REG_AW-1:0] wbReg,
  output logic [DATA_W-1:0] wbData
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [MODE_W-1:0] modeQ;
  logic [DATA_W-1:0] fieldQ, pcQ, eaQ, operandQ, wbValQ;
  logic [REG_AW-1:0] baseQ, idxQ;
  logic [1:0]        sizeQ;

  logic [1:0]        shamt;
  logic [DATA_W-1:0] stepBytes, scaledIdx, eaNext, operandNext, wbNext;

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= MODE_IMM;
      fieldQ <= '0;
      pcQ    <= '0;
      baseQ  <= '0;
      idxQ   <= '0;
      sizeQ  <= '0;
    end else if (stb.capReq) begin
      modeQ  <= reqMode;
      fieldQ <= reqField;
      pcQ    <= pc;
      baseQ  <= reqBaseReg;
      idxQ   <= reqIndexReg;
      sizeQ  <= reqSize;
    end
  end

  // step of 1, 2 or 4 bytes; also the index scale
  assign shamt     = sizeQ[1] ? 2'd2 : {1'b0, sizeQ[0]};
  assign stepBytes = ONE << shamt;
  assign scaledIdx = rfRdDataB << shamt;

  always_comb begin
    case (modeQ)
      MODE_DIRECT,
      MODE_MEMIND:   eaNext = fieldQ;
      MODE_REGIND,
      MODE_POSTINC:  eaNext = rfRdDataA;
      MODE_BASEDISP: eaNext = rfRdDataA + fieldQ;
      MODE_INDEXED:  eaNext = rfRdDataA + scaledIdx + fieldQ;
      MODE_PCREL:    eaNext = pcQ + fieldQ;
      MODE_PREDEC:   eaNext = rfRdDataA - stepBytes;
      default:       eaNext = '0;
    endcase
  end

  assign operandNext = (modeQ == MODE_REG) ? rfRdDataA : fieldQ;
  assign wbNext      = (modeQ == MODE_PREDEC) ? (rfRdDataA - stepBytes)
                                              : (rfRdDataA + stepBytes);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ      <= '0;
      operandQ <= '0;
      wbValQ   <= '0;
    end else begin
      if (stb.capAddr) begin
        eaQ      <= eaNext;
        operandQ <= operandNext;
        wbValQ   <= wbNext;
      end
      if (stb.capPtr)  eaQ      <= memRdata;
      if (stb.capRead) operandQ <= memRdata;
    end
  end

  assign curMode   = modeQ;
  assign rfRdAddrA = baseQ;
  assign rfRdAddrB = idxQ;
  assign memAddr   = eaQ;
  assign operand   = operandQ;
  assign effAddr   = eaQ;
  assign wbReg     = baseQ;
  assign wbData    = wbValQ;

endmodule

// File: rtl/operand_fetch.sv
module operand_fetch
  import ofu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 8,
  localparam int REG_AW = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [MODE_W-1:0] reqMode,
  input  logic [DATA_W-1:0] reqField,
  input  logic [REG_AW-1:0] reqBaseReg,
  input  logic [REG_AW-1:0] reqIndexReg,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] pc,
  output logic [REG_AW-1:0] rfRdAddrA,
  input  logic [DATA_W-1:0] rfRdDataA,
  output logic [REG_AW-1:0] rfRdAddrB,
  input  logic [DATA_W-1:0] rfRdDataB,
  output logic              memValid,
  output logic [DATA_W-1:0] memAddr,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  output logic              done,
  output logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] effAddr,
  output logic              wbEn,
  output logic [REG_AW-1:0] wbReg,
  output logic [DATA_W-1:0] wbData
);

  ctrlStrobe_t       stb;
  logic [MODE_W-1:0] curMode;

  ofu_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .curMode  (curMode),
    .memReady (memReady),
    .reqReady (reqReady),
    .stb      (stb)
  );

  ofu_dpath #(.DATA_W(DATA_W), .REG_AW(REG_AW)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .reqMode     (reqMode),
    .reqField    (reqField),
    .reqBaseReg  (reqBaseReg),
    .reqIndexReg (reqIndexReg),
    .reqSize     (reqSize),
    .pc          (pc),
    .rfRdDataA   (rfRdDataA),
    .rfRdDataB   (rfRdDataB),
    .memRdata    (memRdata),
    .curMode     (curMode),
    .rfRdAddrA   (rfRdAddrA),
    .rfRdAddrB   (rfRdAddrB),
    .memAddr     (memAddr),
    .operand     (operand),
    .effAddr     (effAddr),
    .wbReg       (wbReg),
    .wbData      (wbData)
  );

  assign memValid = stb.memValid;
  assign done     = stb.done;
  assign wbEn     = stb.wbEn;

endmodule

// File: rtl/operand_fetch_checker.sv
module operand_fetch_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [3:0]        reqMode,
  input logic              memValid,
  input logic [DATA_W-1:0] memAddr,
  input logic              memReady,
  input logic              done,
  input logic              wbEn
);

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_wb_with_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> done);

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memValid && !done && !wbEn));

  p_imm_no_mem_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqMode == 4'd0) |=> (!memValid ##1 (done && !memValid && !wbEn)));

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

bind operand_fetch operand_fetch_checker #(.DATA_W(DATA_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqMode  (reqMode),
  .memValid (memValid),
  .memAddr  (memAddr),
  .memReady (memReady),
  .done     (done),
  .wbEn     (wbEn)
);

// File: tb/operand_fetch_test.sv
module operand_fetch_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int RA = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid;
  logic          reqReady;
  logic [3:0]    reqMode;
  logic [DW-1:0] reqField;
  logic [RA-1:0] reqBaseReg, reqIndexReg;
  logic [1:0]    reqSize;
  logic [DW-1:0] pc;
  logic [RA-1:0] rfRdAddrA, rfRdAddrB;
  logic [DW-1:0] rfRdDataA, rfRdDataB;
  logic          memValid, memReady, done, wbEn;
  logic [DW-1:0] memAddr, memRdata, operand, effAddr, wbData;
  logic [RA-1:0] wbReg;

  logic [DW-1:0] rf [8];
  logic [DW-1:0] memArr [256];
  int stallTarget = 0;
  int stallCnt = 0;
  int tests = 0;
  int fails = 0;
  int holdErrs = 0;
  bit prevStall = 1'b0;
  logic [DW-1:0] prevAddr = '0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  operand_fetch uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqMode(reqMode), .reqField(reqField), .reqBaseReg(reqBaseReg),
    .reqIndexReg(reqIndexReg), .reqSize(reqSize), .pc(pc),
    .rfRdAddrA(rfRdAddrA), .rfRdDataA(rfRdDataA),
    .rfRdAddrB(rfRdAddrB), .rfRdDataB(rfRdDataB),
    .memValid(memValid), .memAddr(memAddr), .memReady(memReady),
    .memRdata(memRdata), .done(done), .operand(operand), .effAddr(effAddr),
    .wbEn(wbEn), .wbReg(wbReg), .wbData(wbData)
  );

  // behavioural register file and memory
  assign rfRdDataA = rf[rfRdAddrA];
  assign rfRdDataB = rf[rfRdAddrB];
  assign memRdata  = memArr[memAddr[7:0]];
  assign memReady  = memValid && (stallCnt >= stallTarget);

  always @(posedge clk) begin
    if (memValid && !memReady) stallCnt <= stallCnt + 1;
    else                       stallCnt <= 0;
    if (wbEn) rf[wbReg] <= wbData;
  end

  // R11 monitor, every clock
  always @(negedge clk) begin
    if (rstN && prevStall && (!memValid || memAddr != prevAddr)) holdErrs++;
    prevStall = rstN && memValid && !memReady;
    prevAddr  = memAddr;
  end

  function automatic logic [DW-1:0] memRd(input logic [DW-1:0] a);
    return memArr[a[7:0]];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [3:0] mode, input logic [DW-1:0] field,
                       input int b, input int x, input logic [1:0] size,
                       input int stall, input bit poke, input string tag);
    logic [DW-1:0] expOp, expEa, expWb, stepv, ptr;
    logic [DW-1:0] expAddrs[$];
    logic [DW-1:0] gotAddrs[$];
    bit expWbEn;
    int cnt, memCyc;
    bit sawDone;
    stepv   = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    expOp   = field;
    expEa   = '0;
    expWb   = '0;
    expWbEn = 1'b0;
    case (mode)
      4'd1: expOp = rf[b];
      4'd2: expEa = field;
      4'd3: expEa = rf[b];
      4'd4: expEa = rf[b] + field;
      4'd5: expEa = rf[b] + rf[x] * stepv + field;
      4'd6: begin
        ptr = memRd(field);
        expAddrs.push_back(field);
        expEa = ptr;
      end
      4'd7: expEa = pc + field;
      4'd8: begin expEa = rf[b]; expWb = rf[b] + stepv; expWbEn = 1'b1; end
      4'd9: begin expEa = rf[b] - stepv; expWb = expEa; expWbEn = 1'b1; end
      default: ;
    endcase
    if (mode >= 4'd2 && mode <= 4'd9) begin
      expAddrs.push_back(expEa);
      expOp = memRd(expEa);
    end
    stallTarget = stall;

    @(negedge clk);
    chk(reqReady, {tag, " ready before request"}, {31'd0, reqReady}, 1);
    reqValid    = 1'b1;
    reqMode     = mode;
    reqField    = field;
    reqBaseReg  = RA'(b);
    reqIndexReg = RA'(x);
    reqSize     = size;
    @(negedge clk);
    reqValid = 1'b0;
    cnt = 1; memCyc = 0; sawDone = 0;
    forever begin
      if (poke && cnt == 1) begin
        reqValid = 1'b1; reqMode = 4'd0; reqField = 32'hDEAD_0000;
      end
      if (poke && cnt == 2) reqValid = 1'b0;
      if (memValid) memCyc++;
      if (memValid && memReady) gotAddrs.push_back(memAddr);
      if (done) begin sawDone = 1; break; end
      cnt++;
      if (cnt > 60) break;
      @(negedge clk);
    end
    reqValid = 1'b0;
    chk(sawDone, {tag, " done seen"}, {31'd0, sawDone}, 1);
    chk(operand == expOp, {tag, " operand"}, operand, expOp);
    chk(effAddr == expEa, {tag, " effAddr"}, effAddr, expEa);
    chk(wbEn == expWbEn, {tag, " R9 wbEn"}, {31'd0, wbEn}, {31'd0, expWbEn});
    if (expWbEn) begin
      chk(wbReg == RA'(b), {tag, " wbReg"}, DW'(wbReg), DW'(b));
      chk(wbData == expWb, {tag, " wbData"}, wbData, expWb);
    end
    chk(gotAddrs.size() == expAddrs.size(), {tag, " read count"},
        DW'(gotAddrs.size()), DW'(expAddrs.size()));
    for (int i = 0; i < expAddrs.size() && i < gotAddrs.size(); i++)
      chk(gotAddrs[i] == expAddrs[i], {tag, " read address"}, gotAddrs[i], expAddrs[i]);
    chk(cnt == 2 + memCyc, {tag, " R14 latency"}, DW'(cnt), DW'(2 + memCyc));
    @(negedge clk);
    chk(!done && !wbEn && reqReady, {tag, " R9 done pulse ends"}, {31'd0, done}, 0);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        chk(!done && !memValid, "R10 busy request ignored", {31'd0, done}, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) memArr[i] = (i * 32'h0103_0507) ^ 32'h5A00_0000;
    for (int i = 0; i < 8; i++)   rf[i] = 32'h40 + i * 32'h11;
    rf[2] = 32'd3;
    rstN = 1'b0; reqValid = 1'b0; reqMode = '0; reqField = '0;
    reqBaseReg = '0; reqIndexReg = '0; reqSize = '0; pc = 32'h0000_0080;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(reqReady && !memValid && !done && !wbEn, "R13 reset state",
        {28'd0, reqReady, memValid, done, wbEn}, 32'h8);
    rstN = 1'b1;

    runOp(4'd0,  32'h1234_5678, 1, 0, 2'd2, 0, 0, "R1 immediate");
    runOp(4'd1,  32'h0,         5, 0, 2'd0, 0, 0, "R2 register");
    runOp(4'd2,  32'h0000_0033, 0, 0, 2'd2, 0, 0, "R3 direct");
    runOp(4'd3,  32'h0,         4, 0, 2'd2, 2, 0, "R3 reg indirect stall R11");
    runOp(4'd4,  32'hFFFF_FFF8, 6, 0, 2'd2, 1, 0, "R3 base+disp negative");
    runOp(4'd7,  32'hFFFF_FFF0, 0, 0, 2'd2, 0, 0, "R3 pc-relative negative");
    runOp(4'd5,  32'h0000_0004, 1, 2, 2'd0, 0, 0, "R4 indexed R8 size0");
    runOp(4'd5,  32'h0000_0004, 1, 2, 2'd1, 0, 0, "R4 indexed R8 size1");
    runOp(4'd5,  32'h0000_0004, 1, 2, 2'd2, 3, 0, "R4 indexed R8 size2");
    runOp(4'd5,  32'h0000_0004, 1, 2, 2'd3, 0, 0, "R4 indexed R8 size3");
    runOp(4'd6,  32'h0000_0021, 0, 0, 2'd2, 0, 0, "R5 memory indirect");
    runOp(4'd6,  32'h0000_0047, 0, 0, 2'd2, 2, 0, "R5 memory indirect stall");
    runOp(4'd8,  32'h0,         3, 0, 2'd2, 0, 0, "R6 post-increment size2");
    runOp(4'd8,  32'h0,         3, 0, 2'd0, 1, 0, "R6 post-increment R8 size0");
    runOp(4'd9,  32'h0,         7, 0, 2'd1, 0, 0, "R7 pre-decrement R8 size1");
    runOp(4'd9,  32'h0,         7, 0, 2'd2, 2, 0, "R7 pre-decrement size2");
    runOp(4'd12, 32'hCAFE_0001, 3, 1, 2'd2, 0, 0, "R12 reserved code");
    runOp(4'd15, 32'h0BAD_F00D, 3, 1, 2'd0, 0, 0, "R12 reserved code 15");
    runOp(4'd3,  32'h0,         4, 0, 2'd2, 3, 1, "R10 busy poke");
    chk(holdErrs == 0, "R11 address held while stalled", DW'(holdErrs), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule